// File: doc/BRIEF.md
# MAC Control Frame Statistics Counters

This block sits beside an Ethernet MAC receive path and keeps two 16-bit statistics counters for MAC control frames. At the end of every received frame the MAC raises a one-cycle status strobe. With it come the CRC check result, the frame byte length, a VLAN-tag indication, a control-frame indication (the MAC asserts it for EtherType 0x8808) and the 16-bit control opcode. The block decides from these whether one of its counters advances. One counter tracks flow-control PAUSE requests, which carry opcode 0x0001. The other tracks control frames that carry any other opcode.

Software reads and writes both counters through a small word-addressed register port. Each counter fills the low half of a 32-bit word. The upper half is reserved and always reads as zero. The frame status strobe has no back-pressure: the block accepts a status on every cycle, so it needs no ready signal. A status counts only if it arrives with its strobe.

Top module: `mac_ctl_stats`

## Requirements
- R1: A status strobe with good CRC, the control flag set, a legal length and opcode 0x0001 advances the PAUSE counter (word address 0) by one. The new value is readable with a read issued two cycles after the strobe cycle.
- R2: A status strobe with good CRC, the control flag set, a legal length and any opcode other than 0x0001 advances the other-opcode counter (word address 1) by one, with the same timing as R1.
- R3: For an untagged frame (VLAN flag low) a length is legal from 64 to 1518 bytes inclusive. Lengths of 63 or 1519 count nothing.
- R4: For a tagged frame (VLAN flag high) the upper legal length is 1522 bytes inclusive. A length of 1523 counts nothing, and the lower limit stays 64.
- R5: A status with bad CRC, with the control flag low, or without the strobe leaves both counters unchanged. At most one counter advances per status.
- R6: A counter that holds 0xFFFF wraps to 0x0000 on its next increment.
- R7: When a software write to a counter lands in the same cycle as that counter's increment, the written value is kept and the increment is dropped.
- R8: Word address 0 selects the PAUSE counter and word address 1 selects the other-opcode counter. A write loads bits 15:0 of the write data and ignores bits 31:16. A read returns the counter in bits 15:0 with bits 31:16 zero, one cycle after the read request. Any other address reads as zero, and writes to it change neither counter.
- R9: After reset both counters read as zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| fs_valid | input | 1 | End-of-frame status strobe, one cycle per frame |
| fs_crc_ok | input | 1 | Frame CRC checked good |
| fs_len | input | LEN_W (14) | Frame length in bytes |
| fs_vlan | input | 1 | Frame carries a VLAN tag |
| fs_ctrl | input | 1 | Frame is a MAC control frame |
| fs_opcode | input | 16 | Control opcode of the frame |
| reg_wr | input | 1 | Register write request |
| reg_rd | input | 1 | Register read request |
| reg_addr | input | ADDR_W (4) | Word address |
| reg_wdata | input | 32 | Write data |
| reg_rdata | output | 32 | Read data, valid the cycle after reg_rd |

## Verification
A status strobe is classified at the first clock edge and lands in its counter at the second. A read started in the cycle after the strobe therefore still returns the old value, and a read two cycles after the strobe returns the new one. Read data is registered and is due one edge after the request. A write in the cycle after a strobe meets that strobe's increment, which is the case R7 targets. The bench steps a cycle-accurate reference model once per clock, using the same inputs it drives. It captures each expected read value before the edge that samples the request and compares at the following falling edge, so every comparison sits in the cycle where the result is due.

// File: rtl/mac_ctl_stats_pkg.sv
package mac_ctl_stats_pkg;
  localparam int CNT_W         = 16;
  localparam int REG_W         = 32;
  localparam int OPC_W         = 16;
  localparam int NUM_CNT       = 2;
  localparam int MIN_LEN       = 64;
  localparam int MAX_LEN_PLAIN = 1518;
  localparam int MAX_LEN_TAG   = 1522;
  localparam logic [OPC_W-1:0] PAUSE_OPCODE = 16'h0001;

  typedef enum int {
    CNT_PAUSE = 0,
    CNT_OTHER = 1
  } cnt_idx_e;

  typedef struct packed {
    logic             crc_ok;
    logic             vlan;
    logic             ctrl;
    logic [OPC_W-1:0] opcode;
  } frame_flags_t;
endpackage

// File: rtl/mcs_classifier.sv
module mcs_classifier
  import mac_ctl_stats_pkg::*;
#(
  parameter int LEN_W = 14
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               valid_i,
  input  frame_flags_t       flags_i,
  input  logic [LEN_W-1:0]   len_i,
  output logic [NUM_CNT-1:0] inc_o
);
  logic len_ok;
  logic eligible;
  logic is_pause;
  logic [NUM_CNT-1:0] inc_d;

  // length window: lower bound fixed, upper bound widens for tagged frames
  always_comb begin
    len_ok = (len_i >= LEN_W'(MIN_LEN));
    if (flags_i.vlan) len_ok = len_ok && (len_i <= LEN_W'(MAX_LEN_TAG));
    else              len_ok = len_ok && (len_i <= LEN_W'(MAX_LEN_PLAIN));
  end

  assign eligible = valid_i && flags_i.crc_ok && flags_i.ctrl && len_ok;
  assign is_pause = (flags_i.opcode == PAUSE_OPCODE);

  always_comb begin
    inc_d            = '0;
    inc_d[CNT_PAUSE] = eligible && is_pause;
    inc_d[CNT_OTHER] = eligible && !is_pause;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) inc_o <= '0;
    else        inc_o <= inc_d;
  end
endmodule

// File: rtl/mcs_counter.sv
module mcs_counter #(
  parameter int W = 16
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         inc_i,
  input  logic         wr_i,
  input  logic [W-1:0] wdata_i,
  output logic [W-1:0] cnt_o
);
  // software write overrides a coincident increment; increment wraps naturally
  always_ff @(posedge clk) begin
    if (!rst_n)     cnt_o <= '0;
    else if (wr_i)  cnt_o <= wdata_i;
    else if (inc_i) cnt_o <= cnt_o + W'(1);
  end
endmodule

// File: rtl/mcs_regport.sv
module mcs_regport
  import mac_ctl_stats_pkg::*;
#(
  parameter int ADDR_W = 4
) (
  input  logic                           clk,
  input  logic                           rst_n,
  input  logic                           wr_i,
  input  logic                           rd_i,
  input  logic [ADDR_W-1:0]              addr_i,
  input  logic [NUM_CNT-1:0][CNT_W-1:0]  cnt_i,
  output logic [NUM_CNT-1:0]             wr_sel_o,
  output logic [REG_W-1:0]               rdata_o
);
  localparam int PAD_W = REG_W - CNT_W;

  logic [NUM_CNT-1:0] hit;
  logic [CNT_W-1:0]   rd_mux;

  for (genvar k = 0; k < NUM_CNT; k++) begin : g_dec
    assign hit[k]      = (addr_i == ADDR_W'(k));
    assign wr_sel_o[k] = wr_i && hit[k];
  end

  always_comb begin
    rd_mux = '0;
    for (int k = 0; k < NUM_CNT; k++)
      if (hit[k]) rd_mux = cnt_i[k];
  end

  always_ff @(posedge clk) begin
    if (!rst_n)    rdata_o <= '0;
    else if (rd_i) rdata_o <= {{PAD_W{1'b0}}, rd_mux};
  end
endmodule

// File: rtl/mac_ctl_stats.sv
module mac_ctl_stats
  import mac_ctl_stats_pkg::*;
#(
  parameter int LEN_W  = 14,
  parameter int ADDR_W = 4
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              fs_valid,
  input  logic              fs_crc_ok,
  input  logic [LEN_W-1:0]  fs_len,
  input  logic              fs_vlan,
  input  logic              fs_ctrl,
  input  logic [OPC_W-1:0]  fs_opcode,
  input  logic              reg_wr,
  input  logic              reg_rd,
  input  logic [ADDR_W-1:0] reg_addr,
  input  logic [REG_W-1:0]  reg_wdata,
  output logic [REG_W-1:0]  reg_rdata
);
  frame_flags_t                   flags;
  logic [NUM_CNT-1:0]             inc_vec;
  logic [NUM_CNT-1:0]             wr_sel;
  logic [NUM_CNT-1:0][CNT_W-1:0]  cnt_q;
  logic [CNT_W-1:0]               cnt_pause;
  logic [CNT_W-1:0]               cnt_other;

  assign flags = '{crc_ok: fs_crc_ok, vlan: fs_vlan, ctrl: fs_ctrl, opcode: fs_opcode};

  mcs_classifier #(.LEN_W(LEN_W)) u_cls (
    .clk     (clk),
    .rst_n   (rst_n),
    .valid_i (fs_valid),
    .flags_i (flags),
    .len_i   (fs_len),
    .inc_o   (inc_vec)
  );

  for (genvar k = 0; k < NUM_CNT; k++) begin : g_cnt
    mcs_counter #(.W(CNT_W)) u_ctr (
      .clk     (clk),
      .rst_n   (rst_n),
      .inc_i   (inc_vec[k]),
      .wr_i    (wr_sel[k]),
      .wdata_i (reg_wdata[CNT_W-1:0]),
      .cnt_o   (cnt_q[k])
    );
  end

  mcs_regport #(.ADDR_W(ADDR_W)) u_reg (
    .clk      (clk),
    .rst_n    (rst_n),
    .wr_i     (reg_wr),
    .rd_i     (reg_rd),
    .addr_i   (reg_addr),
    .cnt_i    (cnt_q),
    .wr_sel_o (wr_sel),
    .rdata_o  (reg_rdata)
  );

  assign cnt_pause = cnt_q[CNT_PAUSE];
  assign cnt_other = cnt_q[CNT_OTHER];
endmodule

// File: rtl/mac_ctl_stats_chk.sv
module mac_ctl_stats_chk
  import mac_ctl_stats_pkg::*;
#(
  parameter int ADDR_W = 4
) (
  input logic              clk,
  input logic              rst_n,
  input logic              fs_valid,
  input logic              fs_crc_ok,
  input logic              fs_ctrl,
  input logic              reg_wr,
  input logic [ADDR_W-1:0] reg_addr,
  input logic [REG_W-1:0]  reg_wdata,
  input logic [REG_W-1:0]  reg_rdata,
  input logic [NUM_CNT-1:0] inc_vec,
  input logic [CNT_W-1:0]  cnt_pause,
  input logic [CNT_W-1:0]  cnt_other
);
  logic wr_p, wr_o;
  assign wr_p = reg_wr && (reg_addr == ADDR_W'(0));
  assign wr_o = reg_wr && (reg_addr == ADDR_W'(1));

  p_one_inc_r5: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(inc_vec));

  p_bad_frame_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (!fs_valid || !fs_crc_ok || !fs_ctrl) |=> (inc_vec == '0));

  p_pause_step_r1: assert property (@(posedge clk) disable iff (!rst_n)
    (inc_vec[CNT_PAUSE] && !wr_p) |=> (cnt_pause == CNT_W'($past(cnt_pause) + 1'b1)));

  p_other_step_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (inc_vec[CNT_OTHER] && !wr_o) |=> (cnt_other == CNT_W'($past(cnt_other) + 1'b1)));

  p_wrap_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (inc_vec[CNT_PAUSE] && !wr_p && cnt_pause == 16'hFFFF) |=> (cnt_pause == 16'h0000));

  p_write_wins_r7: assert property (@(posedge clk) disable iff (!rst_n)
    wr_p |=> (cnt_pause == $past(reg_wdata[CNT_W-1:0])));

  p_hold_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (!inc_vec[CNT_OTHER] && !wr_o) |=> $stable(cnt_other));

  p_upper_zero_r8: assert property (@(posedge clk) disable iff (!rst_n)
    reg_rdata[REG_W-1:CNT_W] == '0);
endmodule

bind mac_ctl_stats mac_ctl_stats_chk #(.ADDR_W(ADDR_W)) u_chk (
  .clk       (clk),
  .rst_n     (rst_n),
  .fs_valid  (fs_valid),
  .fs_crc_ok (fs_crc_ok),
  .fs_ctrl   (fs_ctrl),
  .reg_wr    (reg_wr),
  .reg_addr  (reg_addr),
  .reg_wdata (reg_wdata),
  .reg_rdata (reg_rdata),
  .inc_vec   (inc_vec),
  .cnt_pause (cnt_pause),
  .cnt_other (cnt_other)
);

// File: tb/test_mac_ctl_stats.sv
module test_mac_ctl_stats;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        fs_valid = 1'b0;
  logic        fs_crc_ok = 1'b0;
  logic [13:0] fs_len = '0;
  logic        fs_vlan = 1'b0;
  logic        fs_ctrl = 1'b0;
  logic [15:0] fs_opcode = '0;
  logic        reg_wr = 1'b0;
  logic        reg_rd = 1'b0;
  logic [3:0]  reg_addr = '0;
  logic [31:0] reg_wdata = '0;
  logic [31:0] reg_rdata;

  int unsigned n_chk = 0;
  int unsigned n_bad = 0;
  bit          done = 1'b0;

  // reference model state: counters after the last edge, pending increments
  logic [15:0] m_p = '0, m_o = '0;
  bit          pend_p = 0, pend_o = 0;

  always #2 clk = ~clk;

  mac_ctl_stats i_mac_ctl_stats (
    .clk(clk), .rst_n(rst_n), .fs_valid(fs_valid), .fs_crc_ok(fs_crc_ok),
    .fs_len(fs_len), .fs_vlan(fs_vlan), .fs_ctrl(fs_ctrl), .fs_opcode(fs_opcode),
    .reg_wr(reg_wr), .reg_rd(reg_rd), .reg_addr(reg_addr), .reg_wdata(reg_wdata),
    .reg_rdata(reg_rdata)
  );

  function automatic bit counts(bit v, bit crc, int len, bit vlan, bit ctrl);
    int hi = vlan ? 1522 : 1518;
    return v && crc && ctrl && (len >= 64) && (len <= hi);
  endfunction

  function automatic void model_step();
    logic [15:0] np = m_p, no = m_o;
    bit c;
    if (pend_p) np = m_p + 16'd1;
    if (pend_o) no = m_o + 16'd1;
    if (reg_wr && reg_addr == 4'd0) np = reg_wdata[15:0];
    if (reg_wr && reg_addr == 4'd1) no = reg_wdata[15:0];
    c = counts(fs_valid, fs_crc_ok, int'(fs_len), fs_vlan, fs_ctrl);
    pend_p = c && (fs_opcode == 16'h0001);
    pend_o = c && (fs_opcode != 16'h0001);
    m_p = np;
    m_o = no;
  endfunction

  task automatic tick();
    model_step();
    @(negedge clk);
  endtask

  task automatic frame(bit crc, int len, bit vlan, bit ctrl, logic [15:0] op);
    fs_valid = 1; fs_crc_ok = crc; fs_len = 14'(len); fs_vlan = vlan;
    fs_ctrl = ctrl; fs_opcode = op;
    tick();
    fs_valid = 0;
  endtask

  task automatic wr(logic [3:0] a, logic [31:0] d);
    reg_wr = 1; reg_addr = a; reg_wdata = d;
    tick();
    reg_wr = 0;
  endtask

  task automatic rd_check(logic [3:0] a, string tag);
    logic [31:0] exp;
    exp = (a == 4'd0) ? {16'h0, m_p} : (a == 4'd1) ? {16'h0, m_o} : 32'h0;
    reg_rd = 1; reg_addr = a;
    tick();
    reg_rd = 0;
    n_chk++;
    if (reg_rdata !== exp) begin
      n_bad++;
      $display("FAIL %s addr=%0d actual=%h expected=%h", tag, a, reg_rdata, exp);
    end
  endtask

  task automatic settle();
    tick(); tick();
  endtask

  initial begin
    repeat (4) @(negedge clk);
    rst_n = 1;
    // R9: reset state
    rd_check(0, "R9"); rd_check(1, "R9");
    // R1 / R2 basic
    frame(1, 100, 0, 1, 16'h0001); settle(); rd_check(0, "R1");
    frame(1, 200, 0, 1, 16'h0101); settle(); rd_check(1, "R2");
    // R3 untagged bounds
    frame(1, 63, 0, 1, 16'h0001); frame(1, 64, 0, 1, 16'h0001);
    frame(1, 1518, 0, 1, 16'h0001); frame(1, 1519, 0, 1, 16'h0001);
    frame(1, 1522, 0, 1, 16'h0001); settle(); rd_check(0, "R3");
    // R4 tagged bounds
    frame(1, 1522, 1, 1, 16'h0002); frame(1, 1523, 1, 1, 16'h0002);
    frame(1, 63, 1, 1, 16'h0002); frame(1, 64, 1, 1, 16'h0002);
    settle(); rd_check(1, "R4");
    // R5: bad CRC, non-control, no strobe
    frame(0, 100, 0, 1, 16'h0001); frame(0, 100, 0, 1, 16'h0005);
    frame(1, 100, 0, 0, 16'h0001); frame(1, 100, 0, 0, 16'h0003);
    fs_crc_ok = 1; fs_ctrl = 1; fs_len = 100; tick();
    settle(); rd_check(0, "R5"); rd_check(1, "R5");
    // R8: write low half only, other addresses
    wr(0, 32'hABCD_1234); rd_check(0, "R8");
    wr(1, 32'hFFFF_0042); rd_check(1, "R8");
    wr(5, 32'h0000_7777); rd_check(0, "R8"); rd_check(1, "R8"); rd_check(5, "R8");
    // R1 timing: read in cycle after strobe sees old value, two cycles later new value
    frame(1, 64, 0, 1, 16'h0001); rd_check(0, "R1"); rd_check(0, "R1");
    // R6: wrap
    wr(0, 32'h0000_FFFF); frame(1, 500, 1, 1, 16'h0001); settle(); rd_check(0, "R6");
    wr(1, 32'h0000_FFFF); frame(1, 500, 0, 1, 16'h8000); settle(); rd_check(1, "R6");
    // R7: write coinciding with increment
    frame(1, 80, 0, 1, 16'h0001); wr(0, 32'h0000_0300); settle(); rd_check(0, "R7");
    frame(1, 80, 0, 1, 16'h0009); wr(1, 32'h0000_0055); settle(); rd_check(1, "R7");
    // random traffic, R1 R2 R3 R4 R5
    for (int i = 0; i < 2000; i++) begin
      int len;
      logic [15:0] op;
      len = (i % 3 == 0) ? (60 + $urandom_range(0, 8)) : (i % 3 == 1) ? (1514 + $urandom_range(0, 12)) : $urandom_range(0, 2000);
      op = ($urandom_range(0, 1) == 0) ? 16'h0001 : 16'($urandom);
      if ($urandom_range(0, 3) != 0)
        frame(($urandom_range(0, 5) != 0), len, $urandom_range(0, 1), ($urandom_range(0, 4) != 0), op);
      else
        tick();
      if (i % 250 == 249) begin
        rd_check(0, "R1 random"); rd_check(1, "R2 random");
      end
    end
    settle(); rd_check(0, "R1 final"); rd_check(1, "R2 final");
    done = 1;
    $display("  test done: total=%0d bad=%0d", n_chk, n_bad);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      n_chk++; n_bad++;
      $display("FAIL watchdog actual=hung expected=finished");
      $display("  test done: total=%0d bad=%0d", n_chk, n_bad);
      $finish;
    end
  end
endmodule